// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller gathers interrupt events from eight vectored sources and two flag-only sources and presents one level interrupt request with a 3-bit vector index to a processor core. Each source has a sticky request flag. Each vectored source also has an enable bit, and one master enable gates all of them. Some sources are external pins, and their edge detection is part of the block. The internal sources (tick, serial done, timer match, gate closed, watch tick) arrive as single-cycle pulses.

A 3-bit promotion code can raise one source, or the fixed pair of tick and dual-edge pin, to high priority. The nesting depth is held in a 2-bit in-service status. The processor acknowledges with a one-cycle pulse that takes the vector shown in that cycle. The acknowledge clears the winning flag, saves the previous status on a 2-deep stack and raises the status. A return pulse takes the saved status back off the stack. Software may overwrite the status. Writing 00 allows any enabled request to preempt the running handler.

Source indices, which are also the vector values and the default order with the highest first: 0 tick, 1 dual-edge pin, 2 pin A, 3 pin B, 4 serial done, 5 timer match, 6 chip-enable falling edge, 7 gate closed. Flag-only sources: 8 test/key-scan, 9 watch tick.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, these are all zero: flags, enables, master enable, promotion code, status, stack, irq and vec.
- R2: Edge sources are compared with their level at the previous clock:
  - Source 1 flags on both edges.
  - Pin A (source 2) and pin B (source 3) flag on a rising edge when their `edge_sel` bit is 0, and on a falling edge when it is 1.
  - Chip-enable (source 6) flags on a falling edge only.
  - A flag is visible in `flags` after the clock edge that samples the new level.
- R3: Flag 8 is set by a rising test pin or by a falling edge on any key-scan input. Flag 9 is set by a watch pulse. Neither flag ever raises irq.
- R4: A vectored source is a candidate only when its flag, its enable bit and the master enable are all 1.
- R5: Among the candidates, a high-priority source wins over a low-priority one. Within a class, the lowest index wins. `vec` carries the index of the winner.
- R6: Promotion code mapping:
  - 000: no source is high.
  - 001: sources 0 and 1 are high.
  - 010 to 111: only the source whose index equals the code is high.
- R7: A promotion-code write takes effect only while the master enable is 0. Otherwise it is ignored.
- R8: Which candidates may be taken depends on the status:
  - 00: any candidate may be taken.
  - 01: only high candidates may be taken.
  - 10 and 11: no candidate may be taken.
- R9: An acknowledge while irq is 1 does four things:
  - It clears the flag of the shown vector.
  - It pushes the old status.
  - It sets the status to 10 if the taken source is high, and to 01 otherwise.
  - It forces irq to 0 in the next cycle.
- R10: A return pops the stack into the status. A pop from an empty stack gives 00. A push onto a full stack drops the oldest entry. A return in the same cycle as an accepted acknowledge is ignored.
- R11: An event in the same cycle as a clear of the same flag, whether by acknowledge or by `flag_clr`, leaves the flag set.
- R12: A software status write loads `st_wdata` into the status. A return or an accepted acknowledge in the same cycle takes precedence over the write.
- R13: `irq` and `vec` are registered. They reflect the state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_pulse | input | 1 | Tick event pulse (source 0) |
| dual_pin | input | 1 | Dual-edge pin (source 1) |
| pin_a | input | 1 | Pin A (source 2) |
| pin_b | input | 1 | Pin B (source 3) |
| edge_sel | input | 2 | Bit 0 pin A, bit 1 pin B: 0 rising, 1 falling |
| ser_pulse | input | 1 | Serial done pulse (source 4) |
| tmr_pulse | input | 1 | Timer match pulse (source 5) |
| ce_pin | input | 1 | Chip-enable pin, falling edge (source 6) |
| gate_pulse | input | 1 | Gate closed pulse (source 7) |
| test_pin | input | 1 | Test pin, rising edge (flag 8) |
| key_pins | input | 4 | Key-scan inputs, falling edge (flag 8) |
| watch_pulse | input | 1 | Watch tick pulse (flag 9) |
| en_wr | input | 1 | Load enable bits |
| en_wdata | input | 8 | Per-source enables for sources 0..7 |
| mie_wr | input | 1 | Load master enable |
| mie_wdata | input | 1 | Master enable value |
| prio_wr | input | 1 | Load promotion code |
| prio_wdata | input | 3 | Promotion code value |
| st_wr | input | 1 | Load in-service status |
| st_wdata | input | 2 | Status value |
| flag_clr | input | 10 | Per-flag clear pulses |
| ack | input | 1 | Acknowledge pulse |
| reti | input | 1 | Return-from-interrupt pulse |
| irq | output | 1 | Interrupt request level |
| vec | output | 3 | Vector index of the winner |
| flags | output | 10 | Request flags |
| status | output | 2 | In-service status |
| prio_code | output | 3 | Current promotion code |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an acknowledge that clears a flag and a fresh event on that same source. The bench raises the gate pulse in the cycle of the acknowledge and expects the flag to survive. The same collision is provoked through `flag_clr`.

The second pair is an acknowledge and a return. The bench asserts both in one cycle and expects the acknowledge to win: the stack is pushed and the status raised, while the return is dropped.

A behavioural model in the bench, built on a queue for the stack, predicts every output on every cycle, and these collisions are judged against it.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NVEC   = 8;
    localparam int NQUASI = 2;
    localparam int NSRC   = NVEC + NQUASI;
    localparam int VEC_W  = $clog2(NVEC);
    localparam int PRIO_W = 3;
    localparam int NPIN   = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10,
        ST_LOCK = 2'b11
    } nest_st_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
        logic             high;
    } win_t;

    function automatic logic src_is_high(input logic [PRIO_W-1:0] code, input int unsigned idx);
        logic pair_hit;
        logic single_hit;
        pair_hit   = (code == 3'd1) && (idx < 2);
        single_hit = (code >= 3'd2) && (idx == 32'(code));
        return pair_hit || single_hit;
    endfunction

    function automatic logic may_preempt(input nest_st_e st, input logic high);
        case (st)
            ST_IDLE: return 1'b1;
            ST_LOW:  return high;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/nic_edge_bank.sv
module nic_edge_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    output logic [N-1:0] ev
);
    logic [N-1:0] prev;

    // previous level tracks the pin in reset too, so release gives no false edge
    always_ff @(posedge clk) begin
        prev <= pin;
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        assign ev[i] = (rise_en[i] & pin[i] & ~prev[i]) | (fall_en[i] & ~pin[i] & prev[i]);
    end
endmodule

// File: rtl/nic_flags.sv
module nic_flags #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= (flag & ~clr) | ev;
    end

    // R11: an event always lands, whatever clear hits the same bit
    assert_event_sets_R11: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((flag & $past(ev)) == $past(ev)));
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NV = NVEC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NV-1:0]     flag,
    input  logic [NV-1:0]     en,
    input  logic              mie,
    input  logic [PRIO_W-1:0] prio,
    input  nest_st_e          status,
    output win_t              win
);
    logic [NV-1:0] hi_mask, allowed, pend, elig, elig_hi, pick;

    for (genvar i = 0; i < NV; i++) begin : g_cls
        assign hi_mask[i] = src_is_high(prio, i);
        assign allowed[i] = may_preempt(status, hi_mask[i]);
    end

    always_comb begin
        pend    = flag & en & {NV{mie}};
        elig    = pend & allowed;
        elig_hi = elig & hi_mask;
        pick    = (|elig_hi) ? elig_hi : elig;
        win.valid = |pick;
        win.idx   = '0;
        for (int i = NV - 1; i >= 0; i--) begin
            if (pick[i]) win.idx = VEC_W'(i);
        end
        win.high = hi_mask[win.idx];
    end

    assert_win_pending_R4: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (flag[win.idx] && en[win.idx] && mie));
    assert_low_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (status == ST_LOW && win.valid) |-> win.high);
    assert_top_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (status == ST_HIGH || status == ST_LOCK) |-> !win.valid);
endmodule

// File: rtl/nic_nest.sv
module nic_nest
    import nic_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_take,
    input  logic     taken_high,
    input  logic     reti,
    input  logic     sw_wr,
    input  logic [1:0] sw_st,
    output nest_st_e status
);
    nest_st_e stk [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ST_IDLE;
            for (int i = 0; i < DEPTH; i++) stk[i] <= ST_IDLE;
        end else if (ack_take) begin
            stk[0] <= status;
            for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
            status <= taken_high ? ST_HIGH : ST_LOW;
        end else if (reti) begin
            status <= stk[0];
            for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
            stk[DEPTH-1] <= ST_IDLE;
        end else if (sw_wr) begin
            status <= nest_st_e'(sw_st);
        end
    end

    assert_ack_low_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !taken_high) |=> status == ST_LOW);
    assert_ack_high_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_take && taken_high) |=> status == ST_HIGH);
    assert_reti_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack_take) |=> status == $past(stk[0]));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_pulse,
    input  logic        dual_pin,
    input  logic        pin_a,
    input  logic        pin_b,
    input  logic [1:0]  edge_sel,
    input  logic        ser_pulse,
    input  logic        tmr_pulse,
    input  logic        ce_pin,
    input  logic        gate_pulse,
    input  logic        test_pin,
    input  logic [3:0]  key_pins,
    input  logic        watch_pulse,
    input  logic        en_wr,
    input  logic [7:0]  en_wdata,
    input  logic        mie_wr,
    input  logic        mie_wdata,
    input  logic        prio_wr,
    input  logic [2:0]  prio_wdata,
    input  logic        st_wr,
    input  logic [1:0]  st_wdata,
    input  logic [9:0]  flag_clr,
    input  logic        ack,
    input  logic        reti,
    output logic        irq,
    output logic [2:0]  vec,
    output logic [9:0]  flags,
    output logic [1:0]  status,
    output logic [2:0]  prio_code
);
    logic [NPIN-1:0]   pins, rise_en, fall_en, pin_ev;
    logic [NSRC-1:0]   src_ev, clr, flag_q;
    logic [NVEC-1:0]   en_q;
    logic              mie_q;
    logic [PRIO_W-1:0] prio_q;
    logic              irq_q;
    logic [VEC_W-1:0]  vec_q;
    logic              ack_take, taken_high;
    nest_st_e          st_q;
    win_t              win;

    // pin slots: 0 dual, 1 pin A, 2 pin B, 3 chip-enable, 4 test, 5..8 keys
    assign pins    = {key_pins, test_pin, ce_pin, pin_b, pin_a, dual_pin};
    assign rise_en = {4'b0000, 1'b1, 1'b0, ~edge_sel[1], ~edge_sel[0], 1'b1};
    assign fall_en = {4'b1111, 1'b0, 1'b1, edge_sel[1], edge_sel[0], 1'b1};

    nic_edge_bank #(.N(NPIN)) u_edges (
        .clk(clk), .pin(pins), .rise_en(rise_en), .fall_en(fall_en), .ev(pin_ev)
    );

    assign src_ev = {watch_pulse, pin_ev[4] | (|pin_ev[8:5]), gate_pulse, pin_ev[3],
                     tmr_pulse, ser_pulse, pin_ev[2], pin_ev[1], pin_ev[0], tick_pulse};

    assign ack_take   = ack & irq_q;
    assign taken_high = src_is_high(prio_q, 32'(vec_q));
    assign clr        = flag_clr | (ack_take ? (NSRC'(1) << vec_q) : '0);

    nic_flags #(.N(NSRC)) u_flags (
        .clk(clk), .rst(rst), .ev(src_ev), .clr(clr), .flag(flag_q)
    );

    nic_arbiter #(.NV(NVEC)) u_arb (
        .clk(clk), .rst(rst), .flag(flag_q[NVEC-1:0]), .en(en_q), .mie(mie_q),
        .prio(prio_q), .status(st_q), .win(win)
    );

    nic_nest #(.DEPTH(2)) u_nest (
        .clk(clk), .rst(rst), .ack_take(ack_take), .taken_high(taken_high),
        .reti(reti), .sw_wr(st_wr), .sw_st(st_wdata), .status(st_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mie_q  <= 1'b0;
            prio_q <= '0;
            irq_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            if (en_wr)             en_q   <= en_wdata;
            if (mie_wr)            mie_q  <= mie_wdata;
            if (prio_wr && !mie_q) prio_q <= prio_wdata;
            irq_q <= ack_take ? 1'b0 : win.valid;
            vec_q <= win.idx;
        end
    end

    assign irq       = irq_q;
    assign vec       = vec_q;
    assign flags     = flag_q;
    assign status    = st_q;
    assign prio_code = prio_q;

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !irq_q);
    assert_masked_R4: assert property (@(posedge clk) disable iff (rst)
        !mie_q |=> !irq_q);
    assert_prio_locked_R7: assert property (@(posedge clk) disable iff (rst)
        mie_q |=> $stable(prio_q));
    assert_quasi_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_q[NVEC-1:0] == '0) |=> !irq_q);
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, dual = 0, pa = 0, pb = 0, ser = 0, tmr = 0, ce = 1, gate = 0;
    logic test = 0, watch = 0;
    logic [3:0] keys = 4'hF;
    logic [1:0] sel = 2'b00;
    logic en_wr = 0, mie_wr = 0, mie_wd = 0, prio_wr = 0, st_wr = 0, ack = 0, reti = 0;
    logic [7:0] en_wd = 0;
    logic [2:0] prio_wd = 0;
    logic [1:0] st_wd = 0;
    logic [9:0] fclr = 0;
    logic irq;
    logic [2:0] vec, prio_code;
    logic [9:0] flags;
    logic [1:0] status;

    int compared = 0, mismatched = 0, cycles = 0;
    bit started = 0;
    string phase = "R1 reset";

    always #4 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst(rst), .tick_pulse(tick), .dual_pin(dual), .pin_a(pa), .pin_b(pb),
        .edge_sel(sel), .ser_pulse(ser), .tmr_pulse(tmr), .ce_pin(ce), .gate_pulse(gate),
        .test_pin(test), .key_pins(keys), .watch_pulse(watch), .en_wr(en_wr),
        .en_wdata(en_wd), .mie_wr(mie_wr), .mie_wdata(mie_wd), .prio_wr(prio_wr),
        .prio_wdata(prio_wd), .st_wr(st_wr), .st_wdata(st_wd), .flag_clr(fclr),
        .ack(ack), .reti(reti), .irq(irq), .vec(vec), .flags(flags), .status(status),
        .prio_code(prio_code)
    );

    // reference model
    logic [9:0] m_flags = 0;
    logic [7:0] m_en = 0;
    logic m_mie = 0, m_irq = 0;
    logic [2:0] m_prio = 0, m_vec = 0;
    int m_st = 0;
    int m_stack[$];
    logic p_dual = 0, p_a = 0, p_b = 0, p_ce = 1, p_test = 0;
    logic [3:0] p_keys = 4'hF;

    function automatic bit is_hi(int code, int i);
        return (code == 1 && i < 2) || (code >= 2 && code == i);
    endfunction

    always @(posedge clk) begin
        logic [9:0] ev, clr;
        int win, win_hi, nst;
        bit ack_t, elig;
        ev = 0;
        ev[0] = tick;
        ev[1] = dual ^ p_dual;
        ev[2] = sel[0] ? (p_a & ~pa) : (pa & ~p_a);
        ev[3] = sel[1] ? (p_b & ~pb) : (pb & ~p_b);
        ev[4] = ser;
        ev[5] = tmr;
        ev[6] = p_ce & ~ce;
        ev[7] = gate;
        ev[8] = (test & ~p_test) | (|(p_keys & ~keys));
        ev[9] = watch;
        p_dual = dual; p_a = pa; p_b = pb; p_ce = ce; p_test = test; p_keys = keys;
        started = 1;
        if (rst) begin
            m_flags = 0; m_en = 0; m_mie = 0; m_prio = 0; m_irq = 0; m_vec = 0;
            m_st = 0; m_stack.delete();
        end else begin
            win = -1; win_hi = -1;
            for (int i = 7; i >= 0; i--) begin
                elig = m_flags[i] && m_en[i] && m_mie &&
                       (m_st == 0 || (m_st == 1 && is_hi(m_prio, i)));
                if (elig) begin
                    win = i;
                    if (is_hi(m_prio, i)) win_hi = i;
                end
            end
            if (win_hi >= 0) win = win_hi;
            ack_t = ack && m_irq;
            clr = fclr;
            if (ack_t) clr[m_vec] = 1'b1;
            m_flags = (m_flags & ~clr) | ev;
            nst = m_st;
            if (ack_t) begin
                m_stack.push_front(m_st);
                if (m_stack.size() > 2) void'(m_stack.pop_back());
                nst = is_hi(m_prio, m_vec) ? 2 : 1;
            end else if (reti) begin
                nst = (m_stack.size() > 0) ? m_stack.pop_front() : 0;
            end else if (st_wr) begin
                nst = st_wd;
            end
            m_st = nst;
            if (prio_wr && !m_mie) m_prio = prio_wd;
            if (en_wr) m_en = en_wd;
            if (mie_wr) m_mie = mie_wd;
            m_irq = ack_t ? 1'b0 : (win >= 0);
            m_vec = (win >= 0) ? 3'(win) : 3'd0;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL [%s] %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(irq == m_irq, "irq R4 R5 R8 R13", irq, m_irq);
            check(flags == m_flags, "flags R2 R3 R11", flags, m_flags);
            check(status == 2'(m_st), "status R9 R10 R12", status, m_st);
            check(prio_code == m_prio, "prio R6 R7", prio_code, m_prio);
            if (m_irq) check(vec == m_vec, "vec R5 R6", vec, m_vec);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL [watchdog] run hung actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mie(input logic v);
        mie_wr = 1; mie_wd = v; @(negedge clk); mie_wr = 0;
    endtask

    task automatic wr_prio(input logic [2:0] v);
        prio_wr = 1; prio_wd = v; @(negedge clk); prio_wr = 0;
    endtask

    task automatic wr_st(input logic [1:0] v);
        st_wr = 1; st_wd = v; @(negedge clk); st_wr = 0;
    endtask

    task automatic service;
        for (int k = 0; k < 12 && !irq; k++) @(negedge clk);
        ack = 1; @(negedge clk); ack = 0;
        idle(1);
    endtask

    task automatic do_reti;
        reti = 1; @(negedge clk); reti = 0; idle(1);
    endtask

    initial begin
        idle(3);
        rst = 0;
        phase = "R1 reset";
        idle(2);

        phase = "R4 enables";
        en_wr = 1; en_wd = 8'hFF; @(negedge clk); en_wr = 0;
        tick = 1; @(negedge clk); tick = 0;
        idle(3);
        wr_mie(1);
        idle(2);
        phase = "R13 R9 service tick";
        service; do_reti;

        phase = "R4 master enable off";
        wr_mie(0);
        ser = 1; @(negedge clk); ser = 0;
        idle(3);
        wr_mie(1);
        service; do_reti;

        phase = "R5 simultaneous";
        pa = 1; ser = 1; @(negedge clk); ser = 0;
        service;
        phase = "R8 first-come lock";
        idle(4);
        do_reti;
        service; do_reti;
        phase = "R2 ignored falling pin A";
        pa = 0; idle(3);

        phase = "R7 locked priority write";
        wr_prio(3'd4); idle(2);
        wr_mie(0); wr_prio(3'd4); wr_mie(1);

        phase = "R6 R8 high preempts low";
        pb = 1; @(negedge clk); service;
        ser = 1; @(negedge clk); ser = 0;
        service;
        tick = 1; @(negedge clk); tick = 0;
        idle(4);
        do_reti; idle(2); do_reti;
        service; do_reti;

        phase = "R6 pair promotion";
        wr_mie(0); wr_prio(3'd1); wr_mie(1);
        gate = 1; @(negedge clk); gate = 0;
        service;
        dual = 1; @(negedge clk); service;
        do_reti; do_reti;

        phase = "R12 status cleared in handler";
        gate = 1; @(negedge clk); gate = 0;
        service;
        wr_st(2'b00);
        tmr = 1; @(negedge clk); tmr = 0;
        service; idle(2);
        do_reti; do_reti;

        phase = "R10 stack overflow";
        for (int n = 0; n < 3; n++) begin
            gate = 1; @(negedge clk); gate = 0;
            service;
            wr_st(2'b00);
        end
        do_reti; do_reti; do_reti; do_reti;

        phase = "R10 ack with reti";
        gate = 1; @(negedge clk); gate = 0;
        for (int k = 0; k < 12 && !irq; k++) @(negedge clk);
        ack = 1; reti = 1; @(negedge clk); ack = 0; reti = 0;
        idle(2); do_reti;

        phase = "R11 ack with new event";
        gate = 1; @(negedge clk); gate = 0;
        for (int k = 0; k < 12 && !irq; k++) @(negedge clk);
        ack = 1; gate = 1; @(negedge clk); ack = 0; gate = 0;
        idle(3); do_reti; service; do_reti;

        phase = "R11 flag_clr with new event";
        wr_mie(0);
        tmr = 1; @(negedge clk); tmr = 0;
        fclr = 10'h020; tmr = 1; @(negedge clk); fclr = 0; tmr = 0;
        idle(1);
        fclr = 10'h3FF; @(negedge clk); fclr = 0;

        phase = "R3 quasi sources";
        wr_mie(1);
        test = 1; @(negedge clk); idle(2);
        fclr = 10'h100; @(negedge clk); fclr = 0;
        keys = 4'b1011; @(negedge clk); keys = 4'hF; idle(1);
        watch = 1; @(negedge clk); watch = 0;
        test = 0; idle(3);
        fclr = 10'h300; @(negedge clk); fclr = 0;

        phase = "R2 edge selection";
        wr_mie(0);
        sel = 2'b11; idle(2);
        pa = 1; pb = 1; idle(2);
        pa = 0; idle(1); pb = 0; idle(1);
        ce = 0; idle(1); ce = 1; idle(1);
        dual = 0; idle(1); dual = 1; idle(2);
        fclr = 10'h3FF; @(negedge clk); fclr = 0;
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule